// File: doc/BRIEF.md
# Hot-Plug Event Latch and Interrupt Aggregator

This block watches the raw sensor levels of a set of hot-plug slots and turns each change that matters into a sticky event bit. Each slot has five events: card presence changed, isolated power fault, attention button pressed, retention latch moved, and connected power fault. Every slot has one 32-bit word. The word holds the live levels, the event latches, and one interrupt mask per event. A controller word holds the global masks and the command-completion event.

Unmasked events are reduced to a locator word. Bit 0 of the locator means a command completion is pending, and bit i+1 means slot i has an event pending. An interrupt line is raised while any locator bit is set and the global interrupt mask is clear. Software reads a slot word, handles the events it sees, and writes the same value back to clear exactly those events. Sensors are asynchronous and pass through a synchroniser before any edge is detected.

Top module: `hp_event_agg`

## Requirements
- R1: A sensor change reaches its event latch on the third rising clock edge after the change (two synchroniser flops plus the edge register). After only two edges the event bit is still 0.
- R2: Event bits sit in the slot word in this order:
  - bit 16 is set by either edge of either presence bit;
  - bit 17 is set by a 1-to-0 edge of the power-good level;
  - bit 18 is set by a 0-to-1 edge of the button;
  - bit 19 is set by either edge of the latch sensor;
  - bit 20 is set by a 0-to-1 edge of the connected-fault input.
  The opposite edges of the power-good level, the button and the connected-fault input set nothing.
- R3: The slot word shows the synchronised levels. Bit 6 is power good (0 means fault), bit 7 is the button, bit 8 is the latch (1 means open), and bits 11:10 are presence (3 means empty).
- R4: Writing 1 to an event bit clears it, and writing 0 leaves it set. Writing back the value just read clears every event that was read.
- R5: An event edge in the same cycle as a write-1 clear of that bit leaves the bit set.
- R6: Bits 30:24 of a slot word are read/write masks. Bits 28:24 mask events 16..20 from the locator. All seven mask bits reset to 1.
- R7: Only bits 30:24, 20:16, 11:10 and 8:6 of a slot word are implemented. Every other bit reads 0 and ignores writes. After reset a slot word with idle inputs reads 0x7F000C40.
- R8: Locator bit i+1 is 1 exactly when slot i has an event bit set whose mask bit is 0.
- R9: A one-cycle `cmd_done` pulse sets bit 16 of the controller word at the next edge. Writing 1 to bit 16 clears it. Locator bit 0 is bit 16 AND NOT bit 2.
- R10: Controller word bits 3:0 are read/write masks that reset to 0xF. Bit 0 is the global interrupt mask and bit 2 is the command mask. All other controller bits except 16 read 0.
- R11: `irq` is 1 exactly when some locator bit is 1 and controller bit 0 is 0.
- R12: A slot write changes only the slot chosen by `slot_wr_sel`. Events on one slot never appear in another slot's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prsnt_raw | input | 2*NUM_SLOTS | Raw presence pair per slot, slot i at bits 2i+1:2i |
| pgood_raw | input | NUM_SLOTS | Raw power-good level per slot, 0 = fault |
| button_raw | input | NUM_SLOTS | Raw attention-button level per slot |
| latch_raw | input | NUM_SLOTS | Raw latch-open level per slot |
| cfault_raw | input | NUM_SLOTS | Raw connected-fault level per slot |
| cmd_done | input | 1 | One-cycle command-completion pulse |
| slot_wr_en | input | 1 | Slot word write strobe |
| slot_wr_sel | input | SEL_W | Slot index for the write |
| slot_wr_data | input | 32 | Slot write data |
| ctl_wr_en | input | 1 | Controller word write strobe |
| ctl_wr_data | input | 32 | Controller write data |
| irq | output | 1 | Interrupt line |
| locator | output | NUM_SLOTS+1 | Pending locator word |
| slot_rd | output | 32*NUM_SLOTS | All slot words, slot i at bits 32i+31:32i |
| ctl_rd | output | 32 | Controller word |

## Verification
The bench builds the block with four slots and a two-flop synchroniser. Four slots make the write select a real two-bit decode, give the locator four distinct slot bits next to the command bit, and leave enough untouched slots to show that events do not leak between slots. With two synchroniser stages the event latency is three edges, so the bench can check that nothing is latched one edge early. It can also land a clear write on the exact edge where an event is latched.

// File: rtl/hp_pkg.sv
package hp_pkg;
    // Event latch order inside the slot word (bit = SW_EV_LO + index)
    localparam int EV_PRSNT = 0;
    localparam int EV_ISO   = 1;
    localparam int EV_BTN   = 2;
    localparam int EV_LATCH = 3;
    localparam int EV_CONN  = 4;
    localparam int EV_N     = 5;
    localparam int MSK_N    = 7;

    // Slot word field positions
    localparam int SW_LVL_PGOOD = 6;
    localparam int SW_LVL_BTN   = 7;
    localparam int SW_LVL_LATCH = 8;
    localparam int SW_PRSNT_LO  = 10;
    localparam int SW_EV_LO     = 16;
    localparam int SW_MSK_LO    = 24;

    // Controller word field positions
    localparam int CW_MSK_N   = 4;
    localparam int CW_GLOBAL  = 0;
    localparam int CW_CMD_MSK = 2;
    localparam int CW_CMD_DET = 16;

    // Synchronised sensor vector layout
    localparam int SIG_N   = 6;
    localparam int SI_PRS  = 0;
    localparam int SI_PG   = 2;
    localparam int SI_BTN  = 3;
    localparam int SI_LAT  = 4;
    localparam int SI_CFL  = 5;
    localparam logic [SIG_N-1:0] SIG_IDLE = 6'b000111;

    typedef struct packed {
        logic [SIG_N-1:0] prev;
        logic [EV_N-1:0]  ev;
        logic [MSK_N-1:0] msk;
    } slot_st_t;

    typedef struct packed {
        logic [CW_MSK_N-1:0] msk;
        logic                cmd_det;
    } ctl_st_t;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stg_q[k] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/hp_slot_unit.sv
module hp_slot_unit
    import hp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIG_N-1:0] sense_raw,
    input  logic             wr_en,
    input  logic [EV_N-1:0]  wr_ev,
    input  logic [MSK_N-1:0] wr_msk,
    output logic [31:0]      word,
    output logic             pending
);
    logic [SIG_N-1:0] sig;
    logic [EV_N-1:0]  hit;
    logic [EV_N-1:0]  clr;
    slot_st_t         st_d, st_q;

    hp_sync #(
        .W      (SIG_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SIG_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sense_raw),
        .dout (sig)
    );

    always_comb begin
        hit[EV_PRSNT] = |(sig[SI_PRS +: 2] ^ st_q.prev[SI_PRS +: 2]);
        hit[EV_ISO]   = st_q.prev[SI_PG] & ~sig[SI_PG];
        hit[EV_BTN]   = sig[SI_BTN] & ~st_q.prev[SI_BTN];
        hit[EV_LATCH] = sig[SI_LAT] ^ st_q.prev[SI_LAT];
        hit[EV_CONN]  = sig[SI_CFL] & ~st_q.prev[SI_CFL];
        clr           = wr_en ? wr_ev : '0;

        st_d      = st_q;
        st_d.prev = sig;
        st_d.ev   = (st_q.ev & ~clr) | hit;
        if (wr_en) begin
            st_d.msk = wr_msk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= SIG_IDLE;
            st_q.ev   <= '0;
            st_q.msk  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        word                         = '0;
        word[SW_LVL_PGOOD]           = sig[SI_PG];
        word[SW_LVL_BTN]             = sig[SI_BTN];
        word[SW_LVL_LATCH]           = sig[SI_LAT];
        word[SW_PRSNT_LO +: 2]       = sig[SI_PRS +: 2];
        word[SW_EV_LO +: EV_N]       = st_q.ev;
        word[SW_MSK_LO +: MSK_N]     = st_q.msk;
    end

    assign pending = |(st_q.ev & ~st_q.msk[EV_N-1:0]);
endmodule

// File: rtl/hp_ctl_unit.sv
module hp_ctl_unit
    import hp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_done,
    input  logic                wr_en,
    input  logic [CW_MSK_N-1:0] wr_msk,
    input  logic                wr_clr_cmd,
    output logic [31:0]         word,
    output logic                cmd_pend,
    output logic                gmask
);
    ctl_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.cmd_det = (st_q.cmd_det & ~(wr_en & wr_clr_cmd)) | cmd_done;
        if (wr_en) begin
            st_d.msk = wr_msk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.msk     <= '1;
            st_q.cmd_det <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        word                      = '0;
        word[CW_MSK_N-1:0]        = st_q.msk;
        word[CW_CMD_DET]          = st_q.cmd_det;
    end

    assign cmd_pend = st_q.cmd_det & ~st_q.msk[CW_CMD_MSK];
    assign gmask    = st_q.msk[CW_GLOBAL];
endmodule

// File: rtl/hp_event_agg.sv
module hp_event_agg
    import hp_pkg::*;
#(
    parameter int  NUM_SLOTS   = 4,
    parameter int  SYNC_STAGES = 2,
    localparam int SEL_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_SLOTS-1:0] prsnt_raw,
    input  logic [NUM_SLOTS-1:0]   pgood_raw,
    input  logic [NUM_SLOTS-1:0]   button_raw,
    input  logic [NUM_SLOTS-1:0]   latch_raw,
    input  logic [NUM_SLOTS-1:0]   cfault_raw,
    input  logic                   cmd_done,
    input  logic                   slot_wr_en,
    input  logic [SEL_W-1:0]       slot_wr_sel,
    input  logic [31:0]            slot_wr_data,
    input  logic                   ctl_wr_en,
    input  logic [31:0]            ctl_wr_data,
    output logic                   irq,
    output logic [NUM_SLOTS:0]     locator,
    output logic [32*NUM_SLOTS-1:0] slot_rd,
    output logic [31:0]            ctl_rd
);
    logic cmd_pend;
    logic gmask;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{slot_wr_data[31], slot_wr_data[23:21], slot_wr_data[15:0],
                              ctl_wr_data[31:17], ctl_wr_data[15:4]};

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [SIG_N-1:0] sense;
        logic             sel;

        assign sense = {cfault_raw[g], latch_raw[g], button_raw[g],
                        pgood_raw[g], prsnt_raw[2*g +: 2]};
        assign sel   = slot_wr_en && (slot_wr_sel == SEL_W'(g));

        hp_slot_unit #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .sense_raw(sense),
            .wr_en    (sel),
            .wr_ev    (slot_wr_data[SW_EV_LO +: EV_N]),
            .wr_msk   (slot_wr_data[SW_MSK_LO +: MSK_N]),
            .word     (slot_rd[32*g +: 32]),
            .pending  (locator[g+1])
        );
    end

    hp_ctl_unit u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_done  (cmd_done),
        .wr_en     (ctl_wr_en),
        .wr_msk    (ctl_wr_data[CW_MSK_N-1:0]),
        .wr_clr_cmd(ctl_wr_data[CW_CMD_DET]),
        .word      (ctl_rd),
        .cmd_pend  (cmd_pend),
        .gmask     (gmask)
    );

    assign locator[0] = cmd_pend;
    assign irq        = (|locator) & ~gmask;
endmodule

// File: rtl/hp_event_agg_chk.sv
module hp_event_agg_chk #(
    parameter int  NUM_SLOTS = 4,
    localparam int SEL_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    slot_wr_en,
    input logic [SEL_W-1:0]        slot_wr_sel,
    input logic [4:0]              wr_ev,
    input logic                    cmd_done,
    input logic                    irq,
    input logic [NUM_SLOTS:0]      locator,
    input logic [32*NUM_SLOTS-1:0] slot_rd,
    input logic                    gmask,
    input logic                    cmd_det
);
    logic unused_bits;
    assign unused_bits = ^slot_rd;

    assert_cmd_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> cmd_det);

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!gmask && (|locator)));

    assert_irq_raised_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((|locator) && !gmask) |-> irq);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        assert_locator_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            locator[i+1] |-> (|(slot_rd[32*i+16 +: 5] & ~slot_rd[32*i+24 +: 5])));

        for (genvar k = 0; k < 5; k++) begin : g_ev
            assert_event_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_rd[32*i+16+k] && !(slot_wr_en && slot_wr_sel == SEL_W'(i) && wr_ev[k]))
                |=> slot_rd[32*i+16+k]);
        end
    end
endmodule

bind hp_event_agg hp_event_agg_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_wr_en (slot_wr_en),
    .slot_wr_sel(slot_wr_sel),
    .wr_ev      (slot_wr_data[20:16]),
    .cmd_done   (cmd_done),
    .irq        (irq),
    .locator    (locator),
    .slot_rd    (slot_rd),
    .gmask      (ctl_rd[0]),
    .cmd_det    (ctl_rd[16])
);

// File: tb/hp_event_agg_test.sv
module hp_event_agg_test;
    localparam int N  = 4;
    localparam int NV = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*N-1:0] prsnt_raw = '1;
    logic [N-1:0]   pgood_raw = '1;
    logic [N-1:0]   button_raw = '0;
    logic [N-1:0]   latch_raw = '0;
    logic [N-1:0]   cfault_raw = '0;
    logic           cmd_done = 1'b0;
    logic           slot_wr_en = 1'b0;
    logic [1:0]     slot_wr_sel = '0;
    logic [31:0]    slot_wr_data = '0;
    logic           ctl_wr_en = 1'b0;
    logic [31:0]    ctl_wr_data = '0;
    logic           irq;
    logic [N:0]     locator;
    logic [32*N-1:0] slot_rd;
    logic [31:0]    ctl_rd;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    hp_event_agg #(.NUM_SLOTS(N), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .prsnt_raw(prsnt_raw), .pgood_raw(pgood_raw),
        .button_raw(button_raw), .latch_raw(latch_raw), .cfault_raw(cfault_raw),
        .cmd_done(cmd_done), .slot_wr_en(slot_wr_en), .slot_wr_sel(slot_wr_sel),
        .slot_wr_data(slot_wr_data), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .irq(irq), .locator(locator), .slot_rd(slot_rd), .ctl_rd(ctl_rd)
    );

    // {slot[1:0], kind[2:0], expected events[4:0]}
    // kind: 0/1 toggle presence bit, 2 power good, 3 button, 4 latch, 5 connected fault
    localparam logic [9:0] TAB [NV] = '{
        {2'd0, 3'd0, 5'b00001}, {2'd0, 3'd1, 5'b00001},
        {2'd1, 3'd2, 5'b00010}, {2'd1, 3'd2, 5'b00000},
        {2'd2, 3'd3, 5'b00100}, {2'd2, 3'd3, 5'b00000},
        {2'd3, 3'd4, 5'b01000}, {2'd3, 3'd4, 5'b01000},
        {2'd0, 3'd5, 5'b10000}, {2'd0, 3'd5, 5'b00000},
        {2'd3, 3'd0, 5'b00001}, {2'd2, 3'd2, 5'b00010}
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_slot(input int s, input logic [31:0] d);
        slot_wr_en   = 1'b1;
        slot_wr_sel  = 2'(s);
        slot_wr_data = d;
        tick();
        slot_wr_en   = 1'b0;
    endtask

    task automatic wr_ctl(input logic [31:0] d);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = d;
        tick();
        ctl_wr_en   = 1'b0;
    endtask

    function automatic logic [31:0] lvl_word(input int s);
        logic [31:0] w;
        w        = '0;
        w[6]     = pgood_raw[s];
        w[7]     = button_raw[s];
        w[8]     = latch_raw[s];
        w[11:10] = prsnt_raw[2*s +: 2];
        return w;
    endfunction

    function automatic logic [31:0] ev_of(input int s);
        return {27'd0, slot_rd[32*s+16 +: 5]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // Reset state: R6, R7, R10, R11
        for (int s = 0; s < N; s++) chk("R7 reset slot word", slot_rd[32*s +: 32], 32'h7F00_0C40);
        chk("R10 reset ctl word", ctl_rd, 32'h0000_000F);
        chk("R8 reset locator", {27'd0, locator}, 32'd0);
        chk("R11 reset irq", {31'd0, irq}, 32'd0);

        // Table walk: R1, R2, R3, R4, R12
        for (int v = 0; v < NV; v++) begin
            int s;
            int kind;
            logic [31:0] exp;
            s    = int'(TAB[v][9:8]);
            kind = int'(TAB[v][7:5]);
            exp  = {27'd0, TAB[v][4:0]};
            case (kind)
                0: prsnt_raw[2*s]   = ~prsnt_raw[2*s];
                1: prsnt_raw[2*s+1] = ~prsnt_raw[2*s+1];
                2: pgood_raw[s]     = ~pgood_raw[s];
                3: button_raw[s]    = ~button_raw[s];
                4: latch_raw[s]     = ~latch_raw[s];
                default: cfault_raw[s] = ~cfault_raw[s];
            endcase
            tick();
            tick();
            chk("R1 no event after two edges", ev_of(s), 32'd0);
            tick();
            chk("R2 event bits", ev_of(s), exp);
            chk("R3 level bits", {20'd0, slot_rd[32*s +: 12]}, lvl_word(s));
            for (int o = 0; o < N; o++) begin
                if (o != s) chk("R12 other slot clean", ev_of(o), 32'd0);
            end
            chk("R8 masked locator", {27'd0, locator}, 32'd0);
            wr_slot(s, slot_rd[32*s +: 32]);
            chk("R4 write-back clears", ev_of(s), 32'd0);
            chk("R6 masks kept", {25'd0, slot_rd[32*s+24 +: 7]}, 32'h7F);
        end

        // Masks and reserved bits: R6, R7, R12
        wr_slot(1, 32'h0000_0000);
        chk("R6 masks written", slot_rd[32 +: 32], lvl_word(1));
        chk("R12 neighbour masks", {25'd0, slot_rd[24 +: 7]}, 32'h7F);
        wr_slot(1, 32'hFFFF_FFFF);
        chk("R7 reserved ignore writes", slot_rd[32 +: 32], 32'h7F00_0000 | lvl_word(1));

        // Locator and irq: R8, R11
        wr_slot(1, 32'h0000_0000);
        pgood_raw[1] = 1'b0;
        repeat (3) tick();
        chk("R8 slot1 locator", {27'd0, locator}, 32'h4);
        chk("R11 global mask holds irq", {31'd0, irq}, 32'd0);
        wr_ctl(32'h0000_0000);
        chk("R10 ctl masks cleared", ctl_rd, 32'd0);
        chk("R11 irq raised", {31'd0, irq}, 32'd1);
        wr_slot(1, 32'h0200_0000);
        chk("R8 event masked", {27'd0, locator}, 32'd0);
        chk("R11 irq dropped", {31'd0, irq}, 32'd0);
        wr_slot(1, 32'h0000_0000);
        chk("R4 zero write keeps event", ev_of(1), 32'h2);
        chk("R8 unmasked again", {27'd0, locator}, 32'h4);
        wr_slot(1, 32'h0002_0000);
        chk("R4 single clear", ev_of(1), 32'd0);
        chk("R11 irq after clear", {31'd0, irq}, 32'd0);

        // Set beats clear: R5
        latch_raw[1] = 1'b1;
        tick();
        tick();
        wr_slot(1, 32'h0008_0000);
        chk("R5 set wins over clear", ev_of(1), 32'h8);
        wr_slot(1, 32'h0008_0000);
        chk("R5 later clear works", ev_of(1), 32'd0);

        // Command completion: R9, R10
        cmd_done = 1'b1;
        tick();
        cmd_done = 1'b0;
        chk("R9 cmd detected", ctl_rd, 32'h0001_0000);
        chk("R9 locator bit0", {27'd0, locator}, 32'h1);
        chk("R11 irq on cmd", {31'd0, irq}, 32'd1);
        wr_ctl(32'h0000_0004);
        chk("R9 cmd masked", {27'd0, locator}, 32'd0);
        chk("R10 ctl word", ctl_rd, 32'h0001_0004);
        wr_ctl(32'h0001_0004);
        chk("R9 cmd cleared", ctl_rd, 32'h0000_0004);
        wr_ctl(32'hFFFF_FFFF);
        chk("R10 reserved ctl", ctl_rd, 32'h0000_000F);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule